// File: doc/BRIEF.md
# Phase-Frequency Detector with Anti-Backlash Overlap and Lock Indication

This block compares two single-cycle strobes, one from the divided reference path and one from the divided oscillator path. Both strobes arrive in the domain of a fast internal clock. It drives two charge-pump enables, a source enable and a sink enable. An edge that arrives first sets its side. When the other side's edge arrives, both enables stay asserted together for a programmable number of cycles and are then cleared at the same time. This forced overlap removes the dead zone around zero phase error. A polarity input swaps the roles of source and sink, which flips the sign of the loop gain.

A lock output is kept apart from the pump enables. It stays high while the loop is settled and drops low for as many cycles as the phase error lasts. The overlap window is normally hidden from it, except in the longest overlap setting. The block also turns a 3-bit current selection into the pump current the analog stage should deliver, in microamps. Two standby inputs shut the detector down, and a commit pulse from the reprogramming logic restarts acquisition from zero phase error.

Top module: `pfd_abl_top`

## Requirements
- R1: After reset, both pump enables are 0, lock_ok is 1, and cur_ua reports the current for the present current code.
- R2: With pol_swap=0, a ref_stb sets pump_src from the next cycle and a vco_stb sets pump_snk from the next cycle. An enable that is set stays high until the common clear.
- R3: Once both sides are set, both enables stay high together for exactly W cycles and then both drop in the same cycle. W is 1, 4, 8 or 10 for abl_sel 0, 1, 2 or 3.
- R4: With pol_swap=1, the reference side drives pump_snk and the oscillator side drives pump_src.
- R5: For abl_sel 0 to 2, lock_ok is 0 exactly in the cycles where only one side is set. It is 1 when both sides are set or neither is.
- R6: For abl_sel=3, lock_ok is 0 whenever either side is set, so the overlap window also shows as low.
- R7: cur_ua is 175, 250, 350, 500, 700, 1000, 1400 or 2000 for cur_sel 0 through 7.
- R8: While stby_full or stby_part is 1, both enables are 0, lock_ok is 1 and cur_ua is 0. The detector state is held clear, and strobes that arrive during standby have no effect after standby ends.
- R9: A commit pulse clears both sides at the next edge. A strobe that arrives in the same cycle as commit is discarded.
- R10: A strobe that arrives in the cycle where the overlap ends sets its side again. A strobe on a side that is already set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast internal clock |
| rst_n | input | 1 | asynchronous reset, active low |
| ref_stb | input | 1 | one-cycle strobe of the divided reference |
| vco_stb | input | 1 | one-cycle strobe of the divided oscillator |
| abl_sel | input | 2 | overlap width selection |
| pol_swap | input | 1 | 1 swaps the source and sink roles |
| cur_sel | input | 3 | pump current selection |
| stby_full | input | 1 | full standby |
| stby_part | input | 1 | partial standby |
| commit | input | 1 | synchronous reprogramming commit, clears the detector |
| pump_src | output | 1 | source current enable |
| pump_snk | output | 1 | sink current enable |
| lock_ok | output | 1 | high when settled, low for the phase error |
| cur_ua | output | 11 | selected pump current in microamps, 0 in standby |

## Verification
The end of the overlap window can fall in the same cycle as a fresh strobe. A commit can also coincide with a strobe. The bench provokes the first case with simultaneous strobes at the 1-cycle width, followed by another reference strobe exactly in the clear cycle. It provokes the second by sending commit and vco_stb together while the reference side is already set. A cycle-accurate behavioural model predicts every output in every cycle. Directed counts of high and low cycles then confirm that the late strobe survives the clear and that the strobe sent with commit is lost.

// File: rtl/pfd_abl_pkg.sv
package pfd_abl_pkg;

  localparam int CUR_W = 11;

  // pump current in microamps for a 3-bit selection
  function automatic logic [CUR_W-1:0] cur_of_sel(input logic [2:0] sel);
    logic [CUR_W-1:0] v;
    case (sel)
      3'd0: v = 11'd175;
      3'd1: v = 11'd250;
      3'd2: v = 11'd350;
      3'd3: v = 11'd500;
      3'd4: v = 11'd700;
      3'd5: v = 11'd1000;
      3'd6: v = 11'd1400;
      default: v = 11'd2000;
    endcase
    return v;
  endfunction

  typedef struct packed {
    logic ref_side;
    logic vco_side;
  } pfd_state_t;

endpackage

// File: rtl/pfd_abl_width.sv
module pfd_abl_width #(
  parameter int W0 = 1,
  parameter int W1 = 4,
  parameter int W2 = 8,
  parameter int W3 = 10,
  parameter int CNT_W = 4
) (
  input  logic [1:0]       abl_sel,
  output logic [CNT_W-1:0] last_idx,
  output logic             show_ovl
);
  localparam int NSEL = 4;
  logic [CNT_W-1:0] tbl [NSEL];

  // each entry holds width-1, the last counter value of the overlap
  generate
    for (genvar g = 0; g < NSEL; g++) begin : g_tbl
      localparam int WG = (g == 0) ? W0 : (g == 1) ? W1 : (g == 2) ? W2 : W3;
      assign tbl[g] = CNT_W'(WG - 1);
    end
  endgenerate

  assign last_idx = tbl[abl_sel];
  // the widest setting lets the overlap through to the lock output
  assign show_ovl = (abl_sel == 2'd3);
endmodule

// File: rtl/pfd_abl_core.sv
module pfd_abl_core
  import pfd_abl_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_clr,
  input  logic             ref_stb,
  input  logic             vco_stb,
  input  logic [CNT_W-1:0] last_idx,
  output pfd_state_t       st
);
  pfd_state_t       st_q;
  logic [CNT_W-1:0] ovl_cnt;
  logic             both, end_ovl;

  assign both    = st_q.ref_side & st_q.vco_side;
  // >= so that a width reduced in mid-overlap still ends it
  assign end_ovl = both & (ovl_cnt >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      ovl_cnt <= '0;
    end else if (hold_clr) begin
      st_q    <= '0;
      ovl_cnt <= '0;
    end else begin
      st_q.ref_side <= (st_q.ref_side & ~end_ovl) | ref_stb;
      st_q.vco_side <= (st_q.vco_side & ~end_ovl) | vco_stb;
      if (both && !end_ovl) ovl_cnt <= ovl_cnt + 1'b1;
      else                  ovl_cnt <= '0;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/pfd_abl_lock.sv
module pfd_abl_lock
  import pfd_abl_pkg::*;
(
  input  pfd_state_t st,
  input  logic       show_ovl,
  input  logic       standby,
  output logic       lock_ok
);
  logic one_side, any_side;

  assign one_side = st.ref_side ^ st.vco_side;
  assign any_side = st.ref_side | st.vco_side;

  always_comb begin
    if (standby)       lock_ok = 1'b1;
    else if (show_ovl) lock_ok = ~any_side;
    else               lock_ok = ~one_side;
  end
endmodule

// File: rtl/pfd_abl_drive.sv
module pfd_abl_drive
  import pfd_abl_pkg::*;
(
  input  pfd_state_t       st,
  input  logic             pol_swap,
  input  logic             standby,
  input  logic [2:0]       cur_sel,
  output logic             pump_src,
  output logic             pump_snk,
  output logic [CUR_W-1:0] cur_ua
);
  logic src_raw, snk_raw;

  assign src_raw  = pol_swap ? st.vco_side : st.ref_side;
  assign snk_raw  = pol_swap ? st.ref_side : st.vco_side;
  assign pump_src = src_raw & ~standby;
  assign pump_snk = snk_raw & ~standby;
  assign cur_ua   = standby ? '0 : cur_of_sel(cur_sel);
endmodule

// File: rtl/pfd_abl_top.sv
module pfd_abl_top
  import pfd_abl_pkg::*;
#(
  parameter int W0 = 1,
  parameter int W1 = 4,
  parameter int W2 = 8,
  parameter int W3 = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_stb,
  input  logic        vco_stb,
  input  logic [1:0]  abl_sel,
  input  logic        pol_swap,
  input  logic [2:0]  cur_sel,
  input  logic        stby_full,
  input  logic        stby_part,
  input  logic        commit,
  output logic        pump_src,
  output logic        pump_snk,
  output logic        lock_ok,
  output logic [10:0] cur_ua
);
  localparam int WMAX01 = (W0 > W1) ? W0 : W1;
  localparam int WMAX23 = (W2 > W3) ? W2 : W3;
  localparam int WMAX   = (WMAX01 > WMAX23) ? WMAX01 : WMAX23;
  localparam int CNT_W  = (WMAX < 2) ? 1 : $clog2(WMAX);

  logic             standby;
  logic             hold_clr;
  logic [CNT_W-1:0] last_idx;
  logic             show_ovl;
  pfd_state_t       st;

  assign standby  = stby_full | stby_part;
  assign hold_clr = standby | commit;

  pfd_abl_width #(.W0(W0), .W1(W1), .W2(W2), .W3(W3), .CNT_W(CNT_W)) u_width (
    .abl_sel (abl_sel),
    .last_idx(last_idx),
    .show_ovl(show_ovl)
  );

  pfd_abl_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_clr(hold_clr),
    .ref_stb (ref_stb),
    .vco_stb (vco_stb),
    .last_idx(last_idx),
    .st      (st)
  );

  pfd_abl_lock u_lock (
    .st      (st),
    .show_ovl(show_ovl),
    .standby (standby),
    .lock_ok (lock_ok)
  );

  pfd_abl_drive u_drive (
    .st      (st),
    .pol_swap(pol_swap),
    .standby (standby),
    .cur_sel (cur_sel),
    .pump_src(pump_src),
    .pump_snk(pump_snk),
    .cur_ua  (cur_ua)
  );
endmodule

// File: rtl/pfd_abl_chk.sv
module pfd_abl_chk #(
  parameter int WMAX = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stby_full,
  input logic        stby_part,
  input logic        commit,
  input logic        pump_src,
  input logic        pump_snk,
  input logic        lock_ok,
  input logic [10:0] cur_ua
);
  int unsigned run_both;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_both <= 0;
    else if (pump_src && pump_snk) run_both <= run_both + 1;
    else                        run_both <= 0;
  end

  assert_quiet_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_full || stby_part) |-> (!pump_src && !pump_snk && lock_ok && cur_ua == 11'd0));

  assert_commit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!pump_src && !pump_snk));

  assert_overlap_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_both <= WMAX);

  assert_lock_low_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src != pump_snk) |-> !lock_ok);

  assert_lock_high_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_src && !pump_snk) |-> lock_ok);

  assert_current_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stby_full || stby_part) |-> (cur_ua >= 11'd175 && cur_ua <= 11'd2000));
endmodule

bind pfd_abl_top pfd_abl_chk #(.WMAX(10)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stby_full(stby_full),
  .stby_part(stby_part),
  .commit   (commit),
  .pump_src (pump_src),
  .pump_snk (pump_snk),
  .lock_ok  (lock_ok),
  .cur_ua   (cur_ua)
);

// File: tb/pfd_abl_top_tb_top.sv
`timescale 1ns/1ps
module pfd_abl_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ref_stb = 0, vco_stb = 0;
  logic [1:0]  abl_sel = 0;
  logic        pol_swap = 0;
  logic [2:0]  cur_sel = 0;
  logic        stby_full = 0, stby_part = 0, commit = 0;
  logic        pump_src, pump_snk, lock_ok;
  logic [10:0] cur_ua;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  pfd_abl_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .vco_stb(vco_stb),
    .abl_sel(abl_sel), .pol_swap(pol_swap), .cur_sel(cur_sel),
    .stby_full(stby_full), .stby_part(stby_part), .commit(commit),
    .pump_src(pump_src), .pump_snk(pump_snk), .lock_ok(lock_ok), .cur_ua(cur_ua)
  );

  // behavioural reference model
  bit m_r = 0, m_v = 0;
  int m_ovl = 0;

  function automatic int wid(input logic [1:0] c);
    int w[4] = '{1, 4, 8, 10};
    return w[c];
  endfunction

  function automatic int cur_exp(input logic [2:0] c);
    int t[8] = '{175, 250, 350, 500, 700, 1000, 1400, 2000};
    return t[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r = 0; m_v = 0; m_ovl = 0;
    end else if (stby_full || stby_part || commit) begin
      m_r = 0; m_v = 0; m_ovl = 0;
    end else begin
      if (m_r && m_v) begin
        m_ovl++;
        if (m_ovl >= wid(abl_sel)) begin m_r = 0; m_v = 0; end
      end
      if (ref_stb) m_r = 1;
      if (vco_stb) m_v = 1;
      if (!(m_r && m_v)) m_ovl = 0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit sb;
      int e_src, e_snk, e_lock, e_cur;
      sb     = stby_full || stby_part;
      e_src  = sb ? 0 : (pol_swap ? m_v : m_r);
      e_snk  = sb ? 0 : (pol_swap ? m_r : m_v);
      e_lock = sb ? 1 : ((abl_sel == 3) ? !(m_r || m_v) : !(m_r ^ m_v));
      e_cur  = sb ? 0 : cur_exp(cur_sel);
      check(cur_req, "pump_src", pump_src, e_src);
      check(cur_req, "pump_snk", pump_snk, e_snk);
      check(cur_req, "lock_ok", lock_ok, e_lock);
      check(cur_req, "cur_ua", cur_ua, e_cur);
    end
  end

  // counters of high/low cycles over a window
  int c_src, c_snk, c_both, c_lowlock;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input bit r, input bit v);
    ref_stb = r; vco_stb = v;
    tick();
    ref_stb = 0; vco_stb = 0;
  endtask

  task automatic measure(input int n);
    c_src = 0; c_snk = 0; c_both = 0; c_lowlock = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pump_src) c_src++;
      if (pump_snk) c_snk++;
      if (pump_src && pump_snk) c_both++;
      if (!lock_ok) c_lowlock++;
    end
    tick();
  endtask

  // a reference strobe, then an oscillator strobe d cycles later, counted
  task automatic lead_ref(input int d);
    fork
      begin
        ref_stb = 1; tick(); ref_stb = 0;
        for (int i = 1; i < d; i++) tick();
        vco_stb = 1; tick(); vco_stb = 0;
      end
      measure(d + 14);
    join
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    cur_req = "R1";
    @(negedge clk);
    check("R1", "pump_src", pump_src, 0);
    check("R1", "pump_snk", pump_snk, 0);
    check("R1", "lock_ok", lock_ok, 1);
    check("R1", "cur_ua", cur_ua, 175);
    tick();

    // R2 reference leads by 3, width 1: src high 3+1, snk high 1
    cur_req = "R2";
    lead_ref(3);
    check("R2", "src cycles", c_src, 4);
    check("R2", "snk cycles", c_snk, 1);

    // R3 each width with coincident strobes
    cur_req = "R3";
    for (int c = 0; c < 4; c++) begin
      abl_sel = 2'(c);
      tick();
      fork pulse(1, 1); measure(14); join
      check("R3", "overlap cycles", c_both, wid(2'(c)));
    end

    // R4 swapped polarity, reference leads by 5, width 4
    cur_req = "R4"; abl_sel = 1; pol_swap = 1; tick();
    lead_ref(5);
    check("R4", "snk cycles", c_snk, 9);
    check("R4", "src cycles", c_src, 4);
    pol_swap = 0; tick();

    // R5 overlap hidden from lock, width 4, error 5
    cur_req = "R5";
    lead_ref(5);
    check("R5", "lock low cycles", c_lowlock, 5);

    // R6 widest setting shows overlap: 5 + 10
    cur_req = "R6"; abl_sel = 3; tick();
    lead_ref(5);
    check("R6", "lock low cycles", c_lowlock, 15);
    abl_sel = 0; tick();

    // R7 current table
    cur_req = "R7";
    for (int c = 0; c < 8; c++) begin
      cur_sel = 3'(c); tick();
      @(negedge clk);
      check("R7", "cur_ua", cur_ua, cur_exp(3'(c)));
    end
    cur_sel = 2;

    // R8 standby modes discard strobes
    cur_req = "R8";
    stby_full = 1; tick();
    fork pulse(1, 0); measure(4); join
    check("R8", "src in full standby", c_src, 0);
    check("R8", "cur in full standby", cur_ua, 0);
    stby_full = 0; stby_part = 1; tick();
    fork pulse(0, 1); measure(4); join
    check("R8", "snk in partial standby", c_snk, 0);
    stby_part = 0; tick();
    measure(3);
    check("R8", "side set after standby", c_src + c_snk, 0);

    // R9 commit clears and swallows a coincident strobe
    cur_req = "R9";
    pulse(1, 0);
    tick();
    commit = 1; vco_stb = 1; tick(); commit = 0; vco_stb = 0;
    measure(4);
    check("R9", "src after commit", c_src, 0);
    check("R9", "snk after commit", c_snk, 0);

    // R10 strobe in the clear cycle survives; repeat strobe ignored
    cur_req = "R10"; abl_sel = 0; tick();
    pulse(1, 1);
    pulse(1, 0);
    measure(3);
    check("R10", "src after late strobe", c_src, 3);
    commit = 1; tick(); commit = 0; tick();
    fork
      begin pulse(1, 0); pulse(1, 0); pulse(1, 0); pulse(0, 1); end
      measure(10);
    join
    check("R10", "src cycles with repeats", c_src, 4);
    check("R10", "snk cycles with repeats", c_snk, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule